// File: doc/BRIEF.md
# NOR Flash Block Erase Sequencer

This controller erases a single block of a parallel NOR flash array that follows the extended command set with a status register. A host pulses `start` with a word address anywhere inside the target block. The sequencer then raises the programming-voltage enable and writes the erase-setup and erase-confirm command bytes to that address. It reads the status word there once per clock until every chip reports ready or a cycle budget runs out. Afterwards it drops the programming voltage, clears the status register and returns the array to read mode. Finally it pulses `done` with a result code.

The data bus may carry several chips side by side (interleaved lanes). Every command byte is copied into each lane, and the part counts as ready only when all lanes show their ready bit. The error flags of all lanes are merged before they are decoded. The bus read is combinational: `bus_rdata` is sampled on the clock edge that ends a cycle in which `bus_re` is high.

States and transitions: IDLE goes to SETUP on `start`. SETUP goes to CONFIRM. CONFIRM goes to POLL. POLL stays in POLL until all lanes are ready or the budget is exhausted, and then goes to CLEAR. CLEAR goes to RESTORE. RESTORE goes to FINISH. FINISH goes to IDLE.

Top module: `flash_erase_seq`

## Requirements
- R1: One cycle after `start` is seen in IDLE, the block writes 0x20 to the latched block address with `vpp_en` high. In the next cycle it writes 0xD0 to the same address.
- R2: Each command byte appears in every lane of `bus_wdata`, in the low byte of each UNIT_W-wide lane.
- R3: After the confirm write, the block asserts `bus_re` at the block address every cycle. It leaves POLL after the first read in which bit 7 of every lane is set.
- R4: A lane showing bit 7 while another lane does not keeps the block polling.
- R5: If no all-ready read occurs within TIMEOUT_CYC poll cycles, polling stops after exactly TIMEOUT_CYC reads. If no error bit is set, the code is 5 (timeout).
- R6: Error bits are merged from all lanes of the last status read: bit 1 locked (code 1), bit 3 low voltage (code 2), bit 4 program fault (code 3), bit 5 erase fault (code 4). The priority is 1 > 2 > 3 > 4 > timeout. A clean finish gives code 0.
- R7: After polling ends, the block writes 0x50 and then 0xFF to the block address, with `vpp_en` low for both writes.
- R8: `vpp_en` is high from the setup write through the last poll read, and low at all other times.
- R9: `done` is a one-cycle pulse in the cycle after the 0xFF write, with `busy` low. `err_code` holds its value until the next accepted start, which clears it to 0.
- R10: `start` is ignored while `busy` is high.
- R11: After reset, `busy`, `done`, `vpp_en`, `bus_we` and `bus_re` are low and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an erase (accepted only in IDLE) |
| blk_addr | input | ADDR_W | Word address inside the block to erase |
| bus_addr | output | ADDR_W | Flash bus address |
| bus_wdata | output | UNIT_W*LANES | Flash bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | UNIT_W*LANES | Flash bus read data, valid while `bus_re` is high |
| vpp_en | output | 1 | Programming-voltage enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 3 | Result code of the last erase |

## Verification
A behavioural two-lane flash answers the poll reads, and each lane becomes ready after its own number of reads. The tests vary the ready delays of the two lanes, which separates AND-ing of the ready bits from OR-ing. Single-bit and multi-bit error patterns, placed in either lane, expose the decode priority and lane merging. Cases where the part is ready on the last allowed read, misses by one read, or never becomes ready while showing a lock bit pin down the timeout boundary and its rank below the error classes.

// File: rtl/fes_pkg.sv
package fes_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_CONFIRM,
        S_POLL,
        S_CLEAR,
        S_RESTORE,
        S_FINISH
    } fes_state_t;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_LOCKED  = 3'd1,
        ERR_VOLT    = 3'd2,
        ERR_PROG    = 3'd3,
        ERR_ERASE   = 3'd4,
        ERR_TIMEOUT = 3'd5
    } fes_err_t;

    typedef struct packed {
        logic locked;
        logic volt;
        logic prog;
        logic erase;
    } fes_flags_t;

    localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
    localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
    localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
    localparam logic [7:0] CMD_NOP         = 8'h00;

    localparam int BIT_READY  = 7;
    localparam int BIT_LOCKED = 1;
    localparam int BIT_VOLT   = 3;
    localparam int BIT_PROG   = 4;
    localparam int BIT_ERASE  = 5;

endpackage

// File: rtl/fes_lane_fill.sv
module fes_lane_fill #(
    parameter int UNIT_W = 8,
    parameter int LANES  = 2
) (
    input  logic [7:0]              cmd,
    output logic [UNIT_W*LANES-1:0] word
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign word[l*UNIT_W +: UNIT_W] = UNIT_W'(cmd);
    end
endmodule

// File: rtl/fes_status_merge.sv
module fes_status_merge
    import fes_pkg::*;
#(
    parameter int UNIT_W = 8,
    parameter int LANES  = 2
) (
    input  logic [UNIT_W*LANES-1:0] status,
    output logic                    all_ready,
    output fes_flags_t              flags
);
    logic [LANES-1:0] rdy, lk, vl, pg, er;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rdy[l] = status[l*UNIT_W + BIT_READY];
        assign lk[l]  = status[l*UNIT_W + BIT_LOCKED];
        assign vl[l]  = status[l*UNIT_W + BIT_VOLT];
        assign pg[l]  = status[l*UNIT_W + BIT_PROG];
        assign er[l]  = status[l*UNIT_W + BIT_ERASE];
    end

    assign all_ready    = &rdy;
    assign flags.locked = |lk;
    assign flags.volt   = |vl;
    assign flags.prog   = |pg;
    assign flags.erase  = |er;
endmodule

// File: rtl/fes_poll_timer.sv
module fes_poll_timer #(
    parameter int LIMIT = 1500000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import fes_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int UNIT_W      = 8,
    parameter int LANES       = 2,
    parameter int TIMEOUT_CYC = 1500000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [ADDR_W-1:0]       blk_addr,
    output logic [ADDR_W-1:0]       bus_addr,
    output logic [UNIT_W*LANES-1:0] bus_wdata,
    output logic                    bus_we,
    output logic                    bus_re,
    input  logic [UNIT_W*LANES-1:0] bus_rdata,
    output logic                    vpp_en,
    output logic                    busy,
    output logic                    done,
    output logic [2:0]              err_code
);
    localparam int DATA_W = UNIT_W * LANES;

    fes_state_t        state, state_nx;
    logic [ADDR_W-1:0] blk_q;
    fes_err_t          err_q, err_poll;
    logic [7:0]        cmd;
    logic              all_ready, expired, poll_end;
    fes_flags_t        flags;

    fes_status_merge #(.UNIT_W(UNIT_W), .LANES(LANES)) u_merge (
        .status    (bus_rdata),
        .all_ready (all_ready),
        .flags     (flags)
    );

    fes_poll_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (state == S_POLL),
        .expired (expired)
    );

    fes_lane_fill #(.UNIT_W(UNIT_W), .LANES(LANES)) u_fill (
        .cmd  (cmd),
        .word (bus_wdata)
    );

    assign poll_end = (state == S_POLL) && (all_ready || expired);

    always_comb begin
        if      (flags.locked) err_poll = ERR_LOCKED;
        else if (flags.volt)   err_poll = ERR_VOLT;
        else if (flags.prog)   err_poll = ERR_PROG;
        else if (flags.erase)  err_poll = ERR_ERASE;
        else if (!all_ready)   err_poll = ERR_TIMEOUT;
        else                   err_poll = ERR_NONE;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_SETUP;
            S_SETUP:   state_nx = S_CONFIRM;
            S_CONFIRM: state_nx = S_POLL;
            S_POLL:    if (poll_end) state_nx = S_CLEAR;
            S_CLEAR:   state_nx = S_RESTORE;
            S_RESTORE: state_nx = S_FINISH;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            blk_q <= '0;
            err_q <= ERR_NONE;
        end else begin
            state <= state_nx;
            if (state == S_IDLE && start) begin
                blk_q <= blk_addr;
                err_q <= ERR_NONE;
            end else if (poll_end) begin
                err_q <= err_poll;
            end
        end
    end

    always_comb begin
        cmd    = CMD_NOP;
        bus_we = 1'b0;
        bus_re = 1'b0;
        vpp_en = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            S_IDLE:    busy = 1'b0;
            S_SETUP:   begin cmd = CMD_ERASE_SETUP; bus_we = 1'b1; vpp_en = 1'b1; end
            S_CONFIRM: begin cmd = CMD_CONFIRM;     bus_we = 1'b1; vpp_en = 1'b1; end
            S_POLL:    begin bus_re = 1'b1; vpp_en = 1'b1; end
            S_CLEAR:   begin cmd = CMD_CLR_STATUS;  bus_we = 1'b1; end
            S_RESTORE: begin cmd = CMD_READ_ARRAY;  bus_we = 1'b1; end
            S_FINISH:  begin busy = 1'b0; done = 1'b1; end
            default:   busy = 1'b0;
        endcase
    end

    assign bus_addr = blk_q;
    assign err_code = err_q;

    logic unused_w;
    assign unused_w = ^DATA_W;
endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic       bus_we,
    input logic       bus_re,
    input logic       vpp_en,
    input logic [2:0] err_code
);
    // R3
    read_not_write_chk: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> !bus_we);

    // R8
    read_has_vpp_chk: assert property (@(posedge clk) disable iff (rst)
        bus_re |-> vpp_en);

    // R7
    vpp_drop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vpp_en) |-> bus_we);

    // R1
    first_busy_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (bus_we && vpp_en));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(err_code) |-> busy);

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_we && !bus_re && !vpp_en));
endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .vpp_en   (vpp_en),
    .err_code (err_code)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int TMO = 20;
    localparam int NVEC = 12;

    // {lane0 final, lane1 final, lane0 delay, lane1 delay, expected code}
    localparam logic [7:0] VEC [NVEC][5] = '{
        '{8'h80, 8'h80, 8'd0,  8'd0, 8'd0},
        '{8'h80, 8'h80, 8'd3,  8'd7, 8'd0},
        '{8'h82, 8'h80, 8'd2,  8'd1, 8'd1},
        '{8'h80, 8'h88, 8'd0,  8'd4, 8'd2},
        '{8'h90, 8'hA0, 8'd1,  8'd1, 8'd3},
        '{8'h80, 8'hA0, 8'd0,  8'd2, 8'd4},
        '{8'h8A, 8'hB0, 8'd0,  8'd0, 8'd1},
        '{8'h98, 8'h80, 8'd0,  8'd0, 8'd2},
        '{8'h80, 8'h00, 8'd0,  8'd0, 8'd5},
        '{8'h80, 8'h02, 8'd0,  8'd0, 8'd1},
        '{8'h80, 8'h80, 8'd19, 8'd0, 8'd0},
        '{8'h80, 8'h80, 8'd20, 8'd0, 8'd5}
    };

    logic          clk = 0;
    logic          rst = 1;
    logic          start = 0;
    logic [AW-1:0] blk_addr = '0;
    logic [AW-1:0] bus_addr;
    logic [15:0]   bus_wdata, bus_rdata;
    logic          bus_we, bus_re, vpp_en, busy, done;
    logic [2:0]    err_code;

    int n_chk = 0, n_bad = 0;
    logic [7:0] s0, s1, d0, d1;
    int rd_cnt;

    flash_erase_seq #(.ADDR_W(AW), .UNIT_W(8), .LANES(2), .TIMEOUT_CYC(TMO)) u0 (
        .clk(clk), .rst(rst), .start(start), .blk_addr(blk_addr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_re(bus_re), .bus_rdata(bus_rdata), .vpp_en(vpp_en),
        .busy(busy), .done(done), .err_code(err_code)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural flash: each lane shows 0x00 until its delay in reads has passed
    always_ff @(posedge clk) begin
        if (bus_we && bus_wdata == 16'hD0D0) rd_cnt <= 0;
        else if (bus_re)                     rd_cnt <= rd_cnt + 1;
    end
    assign bus_rdata = {(rd_cnt >= int'(d1)) ? s1 : 8'h00,
                        (rd_cnt >= int'(d0)) ? s0 : 8'h00};

    // monitor
    logic [15:0] wlog [8];
    logic        wvpp [8];
    int wn, rn, addr_bad, dn;
    always @(negedge clk) begin
        if (bus_we) begin
            if (wn < 8) begin wlog[wn] = bus_wdata; wvpp[wn] = vpp_en; end
            wn++;
            if (bus_addr != blk_addr) addr_bad++;
        end
        if (bus_re) begin
            rn++;
            if (bus_addr != blk_addr) addr_bad++;
        end
        if (done) dn++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        wn = 0; rn = 0; addr_bad = 0; dn = 0;
    endtask

    task automatic pulse_start(input logic [AW-1:0] a);
        @(negedge clk);
        blk_addr = a;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic wait_done();
        int guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 200, "watchdog", guard, 200);
    endtask

    localparam logic [15:0] SEQ [4] = '{16'h2020, 16'hD0D0, 16'h5050, 16'hFFFF};

    task automatic check_seq(input string tag);
        check(wn == 4, {tag, " R7 write count"}, wn, 4);
        for (int k = 0; k < 4; k++) begin
            check(wlog[k] == SEQ[k], {tag, " R1 R2 R7 command"}, wlog[k], SEQ[k]);
            check(wvpp[k] == (k < 2), {tag, " R8 vpp at write"}, wvpp[k], (k < 2));
        end
        check(addr_bad == 0, {tag, " R3 address"}, addr_bad, 0);
    endtask

    initial begin
        int exp_reads, mx;
        s0 = 8'h80; s1 = 8'h80; d0 = 0; d1 = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !vpp_en && !bus_we && !bus_re && err_code == 0,
              "R11 reset state", {busy, done, vpp_en, bus_we, bus_re, err_code}, 0);
        rst = 0;
        @(negedge clk);

        for (int v = 0; v < NVEC; v++) begin
            s0 = VEC[v][0]; s1 = VEC[v][1]; d0 = VEC[v][2]; d1 = VEC[v][3];
            clear_log();
            pulse_start(AW'(20'h01000 + v * 20'h00100));
            check(busy && vpp_en, "R1 busy and vpp after start", {busy, vpp_en}, 3);
            wait_done();
            check(!busy, "R9 done with busy low", busy, 0);
            check(err_code == VEC[v][4][2:0], "R5 R6 code", err_code, VEC[v][4]);
            mx = (d0 > d1) ? d0 : d1;
            exp_reads = (s0[7] && s1[7] && mx < TMO) ? mx + 1 : TMO;
            check(rn == exp_reads, "R3 R4 R5 poll reads", rn, exp_reads);
            @(negedge clk);
            check_seq("vec");
            check(!done && dn == 1, "R9 single done", dn, 1);
        end

        // R9 code held, then cleared by next start; R10 start ignored while busy
        s0 = 8'h82; s1 = 8'h80; d0 = 0; d1 = 0;
        clear_log();
        pulse_start(20'h02000);
        wait_done();
        repeat (5) @(negedge clk);
        check(err_code == 1, "R9 code held", err_code, 1);
        s0 = 8'h80; d0 = 6; d1 = 6;
        clear_log();
        pulse_start(20'h03000);
        check(err_code == 0, "R9 code cleared on start", err_code, 0);
        repeat (3) @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        wait_done();
        repeat (8) @(negedge clk);
        check(wn == 4, "R10 start while busy ignored", wn, 4);
        check(dn == 1, "R10 one done", dn, 1);
        check(rn == 7, "R4 reads with equal delays", rn, 7);
        check(!busy, "R10 idle after", busy, 0);

        // R11 reset mid-poll
        d0 = 30;
        clear_log();
        pulse_start(20'h04000);
        repeat (4) @(negedge clk);
        rst = 1;
        @(negedge clk);
        check(!busy && !vpp_en && !bus_re && err_code == 0, "R11 reset mid-poll",
              {busy, vpp_en, bus_re, err_code}, 0);
        rst = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule